// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block runs single accesses on a shared 16-bit address/data bus toward an external memory or peripheral. The external side holds the upper address bits in an address latch. A request carries a 24-bit address, a direction, write data and a width mode, and is handed over with a valid/ready handshake. The sequencer decides whether the external latch needs a new upper address. If it does, it spends one clock on a latch cycle. It then runs a read or write strobe whose length comes from a 5-bit duration input.

The external latch is reloaded only when the upper 16 address bits change. Streams of accesses inside one 256-byte window therefore skip the latch cycle. In 8-bit mode the low address byte travels on the upper bus lanes during the data cycle itself, and data uses the lower lanes. In 16-bit mode the data cycle carries data only on all 16 lanes, and the address comes entirely from the external latch. Read data returns with a one-clock valid pulse.

Top module: `mux_bus_seq`

## Requirements
- R1: A latch cycle precedes a data cycle exactly when no upper address is held, or when addr[23:8] differs from the upper address held. After reset nothing is held, so the first access always has a latch cycle.
- R2: A latch cycle lasts one clock with `ale`=1, `bus_out`=addr[23:8], `bus_oe`=2'b11 and `addr_lo`=addr[7:0].
- R3: During a latch cycle both `rd_n` and `wr_n` are 1.
- R4: The strobe (`rd_n` or `wr_n` low) lasts `cfg_dur` clocks, and a value of 0 gives 1 clock. The two strobes are never low together.
- R5: Lanes during a data cycle depend on `req_wide`. When it is 0 (8-bit), bus_out[15:8]=addr[7:0]; a write drives bus_out[7:0]=wdata[7:0] with `bus_oe`=2'b11, and a read drives `bus_oe`=2'b10. When it is 1 (16-bit), a write drives bus_out=wdata with `bus_oe`=2'b11, and a read drives `bus_oe`=2'b00. Bit 1 of `bus_oe` enables lanes 15:8 and bit 0 enables lanes 7:0.
- R6: Read data is the value of `bus_in` at the clock edge where `rd_n` rises. It is presented on `rdata` with `rdata_valid` high for exactly the one clock after that edge. In 8-bit mode it is `{8'h00, bus_in[7:0]}`.
- R7: A write drives the same bus value with `bus_oe`=2'b11 for one clock before `wr_n` falls and for one clock after it rises.
- R8: After a read strobe there is exactly one clock with `bus_oe`=2'b00 and `req_ready`=0 before the sequencer accepts again.
- R9: `req_ready` is 1 only while idle. A request is taken only on a clock where `req_valid` and `req_ready` are both 1, and a request presented while busy has no effect.
- R10: Out of reset, `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `bus_oe`=2'b00 and `rdata_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | 24 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| req_wdata | input | 16 | Write data |
| cfg_dur | input | 5 | Strobe length in clocks (0 treated as 1) |
| bus_out | output | 16 | Bus value driven |
| bus_oe | output | 2 | Lane enables: bit 1 for 15:8, bit 0 for 7:0 |
| bus_in | input | 16 | Bus value seen |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_lo | output | 8 | Low address byte, valid during latch cycle |
| rdata | output | 16 | Read data |
| rdata_valid | output | 1 | Read data valid pulse |

## Verification
On every cycle the assertions check the following:
- Strobes stay inactive and the bus is fully driven during a latch pulse, and that pulse is never longer than a clock.
- The two strobes never overlap.
- The bus is driven in the clock before a write strobe.
- Every read-strobe release brings a data-valid pulse and an undriven bus while the sequencer is not ready.
- `req_ready` is low whenever a strobe or latch pulse is active.

Only the bench scenarios can show which accesses skip the latch cycle, the exact strobe lengths for different `cfg_dur` values, the lane contents in each width mode, the captured read values, and that a request offered while busy is dropped.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

    parameter int ADDR_W = 24;
    parameter int DATA_W = 16;
    parameter int DUR_W  = 5;
    localparam int LANE_W = DATA_W / 2;
    localparam int UP_W   = ADDR_W - LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_TURN
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              wide;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DUR_W-1:0] eff_dur(input logic [DUR_W-1:0] d);
        return (d == '0) ? DUR_W'(1) : d;
    endfunction

endpackage

// File: rtl/upper_addr_track.sv
module upper_addr_track
    import mux_bus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic [UP_W-1:0] upd_val,
    input  logic [UP_W-1:0] cmp_val,
    output logic            hit
);
    logic            held_ok;
    logic [UP_W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_ok <= 1'b0;
            held    <= '0;
        end else if (upd) begin
            held_ok <= 1'b1;
            held    <= upd_val;
        end
    end

    assign hit = held_ok && (held == cmp_val);
endmodule

// File: rtl/strobe_timer.sv
module strobe_timer
    import mux_bus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DUR_W-1:0] dur,
    output logic             last
);
    logic [DUR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff_dur(dur) - DUR_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - DUR_W'(1);
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/bus_lane_drive.sv
module bus_lane_drive
    import mux_bus_pkg::*;
(
    input  seq_state_e        state,
    input  bus_req_t          cur,
    output logic [DATA_W-1:0] bus_out,
    output logic [1:0]        bus_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [LANE_W-1:0] addr_lo
);
    logic data_phase;

    assign data_phase = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign addr_lo    = cur.addr[LANE_W-1:0];

    always_comb begin
        bus_out = '0;
        bus_oe  = 2'b00;
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        if (state == ST_ALE) begin
            ale     = 1'b1;
            bus_out = cur.addr[ADDR_W-1:LANE_W];
            bus_oe  = 2'b11;
        end else if (data_phase) begin
            rd_n = !((state == ST_STROBE) && !cur.write);
            wr_n = !((state == ST_STROBE) && cur.write);
            if (cur.wide) begin
                if (cur.write) begin
                    bus_out = cur.wdata;
                    bus_oe  = 2'b11;
                end
            end else begin
                bus_out[DATA_W-1:LANE_W] = cur.addr[LANE_W-1:0];
                if (cur.write) begin
                    bus_out[LANE_W-1:0] = cur.wdata[LANE_W-1:0];
                    bus_oe = 2'b11;
                end else begin
                    bus_oe = 2'b10;
                end
            end
        end
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mux_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DUR_W-1:0]  cfg_dur,
    output logic [DATA_W-1:0] bus_out,
    output logic [1:0]        bus_oe,
    input  logic [DATA_W-1:0] bus_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [LANE_W-1:0] addr_lo,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    seq_state_e state, state_nx;
    bus_req_t   cur;
    logic       up_hit, tm_last, tm_load, take;

    assign req_ready = (state == ST_IDLE);
    assign take      = req_valid && req_ready;

    upper_addr_track u_track (
        .clk     (clk),
        .rst     (rst),
        .upd     (state == ST_ALE),
        .upd_val (cur.addr[ADDR_W-1:LANE_W]),
        .cmp_val (req_addr[ADDR_W-1:LANE_W]),
        .hit     (up_hit)
    );

    strobe_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tm_load),
        .dur  (cfg_dur),
        .last (tm_last)
    );

    bus_lane_drive u_drive (
        .state   (state),
        .cur     (cur),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr_lo (addr_lo)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (take) state_nx = !up_hit ? ST_ALE : (req_write ? ST_SETUP : ST_STROBE);
            ST_ALE:    state_nx = cur.write ? ST_SETUP : ST_STROBE;
            ST_SETUP:  state_nx = ST_STROBE;
            ST_STROBE: if (tm_last) state_nx = cur.write ? ST_HOLD : ST_TURN;
            ST_HOLD:   state_nx = ST_IDLE;
            ST_TURN:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign tm_load = (state_nx == ST_STROBE) && (state != ST_STROBE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cur         <= '0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            state       <= state_nx;
            rdata_valid <= 1'b0;
            if (take) begin
                cur.addr  <= req_addr;
                cur.write <= req_write;
                cur.wide  <= req_wide;
                cur.wdata <= req_wdata;
            end
            if ((state == ST_STROBE) && tm_last && !cur.write) begin
                rdata_valid <= 1'b1;
                rdata       <= cur.wide ? bus_in : {{LANE_W{1'b0}}, bus_in[LANE_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] bus_oe,
    input logic       rdata_valid
);
    // R3
    ale_quiet_chk: assert property (@(posedge clk) disable iff (rst) ale |-> (rd_n && wr_n));
    // R2
    ale_width_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
    // R2
    ale_drive_chk: assert property (@(posedge clk) disable iff (rst) ale |-> (bus_oe == 2'b11));
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
    // R7
    wr_setup_chk: assert property (@(posedge clk) disable iff (rst) $fell(wr_n) |-> ($past(bus_oe) == 2'b11));
    // R6
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst) $rose(rd_n) |-> rdata_valid);
    // R8
    rd_turn_chk: assert property (@(posedge clk) disable iff (rst) $rose(rd_n) |-> (bus_oe == 2'b00 && !req_ready));
    // R9
    busy_chk: assert property (@(posedge clk) disable iff (rst) (ale || !rd_n || !wr_n) |-> !req_ready);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .bus_oe      (bus_oe),
    .rdata_valid (rdata_valid)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [4:0]  cfg_dur = '0;
    logic [15:0] bus_out;
    logic [1:0]  bus_oe;
    logic [15:0] bus_in;
    logic        ale, rd_n, wr_n;
    logic [7:0]  addr_lo;
    logic [15:0] rdata;
    logic        rdata_valid;
    logic [15:0] rd_val = '0;

    int checks = 0;
    int fails  = 0;

    // observations of one access
    int          n_ale, n_rd, n_wr, n_turn, n_rv;
    logic [15:0] ale_bus, wr_bus, rd_bus, rv_data;
    logic [7:0]  ale_lo;
    logic [1:0]  rd_oe, wr_oe;
    bit          quiet_bad, setup_bad, hold_bad, turn_bad;

    assign bus_in = !rd_n ? rd_val : 16'hDEAD;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_seq i_mux_bus_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
        .req_wdata(req_wdata), .cfg_dur(cfg_dur), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .addr_lo(addr_lo), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Issues one access and records what appears on the pins until idle again.
    task automatic do_access(input logic [23:0] a, input bit wr, input bit wide,
                             input logic [15:0] wd, input logic [4:0] dur,
                             input logic [15:0] rv, input bit poke_busy);
        logic        prev_wr_n;
        logic [1:0]  prev_oe;
        logic [15:0] prev_bus;
        bit          seen_rd;
        int          guard;
        n_ale = 0; n_rd = 0; n_wr = 0; n_turn = 0; n_rv = 0;
        quiet_bad = 0; setup_bad = 0; hold_bad = 0; turn_bad = 0;
        ale_bus = '0; ale_lo = '0; wr_bus = '0; rd_bus = '0; rv_data = '0;
        rd_oe = 2'b01; wr_oe = 2'b00; seen_rd = 0;
        @(negedge clk);
        req_addr = a; req_write = wr; req_wide = wide; req_wdata = wd;
        cfg_dur = dur; rd_val = rv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        prev_wr_n = 1'b1; prev_oe = 2'b00; prev_bus = '0;
        guard = 0;
        while (!req_ready && guard < 100) begin
            if (poke_busy) begin
                req_valid = 1'b1; req_addr = 24'hFFFF00; req_write = 1'b1;
            end
            if (ale) begin
                n_ale++; ale_bus = bus_out; ale_lo = addr_lo;
                if (!(rd_n && wr_n)) quiet_bad = 1;
            end
            if (!rd_n) begin
                n_rd++; rd_oe = bus_oe; rd_bus = bus_out; seen_rd = 1;
            end
            if (!wr_n) begin
                n_wr++; wr_bus = bus_out; wr_oe = bus_oe;
                if (prev_wr_n && !(prev_oe == 2'b11 && prev_bus == bus_out)) setup_bad = 1;
            end
            if (wr_n && !prev_wr_n && !(bus_oe == 2'b11 && bus_out == wr_bus)) hold_bad = 1;
            if (seen_rd && rd_n && !ale) begin
                n_turn++;
                if (bus_oe != 2'b00) turn_bad = 1;
            end
            if (rdata_valid) begin
                n_rv++; rv_data = rdata;
            end
            prev_wr_n = wr_n; prev_oe = bus_oe; prev_bus = bus_out;
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        chk(guard < 100, "R9", "sequencer returned to idle", guard, 0);
        if (rdata_valid) n_rv++;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        chk(ale == 1'b0, "R10", "ale after reset", ale, 0);
        chk(rd_n && wr_n, "R10", "strobes after reset", {rd_n, wr_n}, 2'b11);
        chk(bus_oe == 2'b00, "R10", "oe after reset", bus_oe, 0);
        chk(rdata_valid == 1'b0, "R10", "valid after reset", rdata_valid, 0);
    endtask

    task automatic t_first_read_wide();
        do_access(24'h123456, 1'b0, 1'b1, 16'h0, 5'd3, 16'hBEEF, 1'b0);
        chk(n_ale == 1, "R1", "latch cycle on first access", n_ale, 1);
        chk(ale_bus == 16'h1234, "R2", "upper address on bus", ale_bus, 16'h1234);
        chk(ale_lo == 8'h56, "R2", "low address port", ale_lo, 8'h56);
        chk(!quiet_bad, "R3", "strobes idle in latch cycle", quiet_bad, 0);
        chk(n_rd == 3, "R4", "read strobe length", n_rd, 3);
        chk(rd_oe == 2'b00, "R5", "16-bit read lanes undriven", rd_oe, 0);
        chk(n_rv == 1, "R6", "one valid pulse", n_rv, 1);
        chk(rv_data == 16'hBEEF, "R6", "16-bit read data", rv_data, 16'hBEEF);
        chk(n_turn == 1 && !turn_bad, "R8", "turnaround clock", n_turn, 1);
    endtask

    task automatic t_write_hit_wide_poke();
        do_access(24'h1234A0, 1'b1, 1'b1, 16'hC0DE, 5'd1, 16'h0, 1'b1);
        chk(n_ale == 0, "R1", "latch skipped on same upper address", n_ale, 0);
        chk(n_wr == 1, "R4", "write strobe length", n_wr, 1);
        chk(wr_bus == 16'hC0DE, "R5", "16-bit write data", wr_bus, 16'hC0DE);
        chk(wr_oe == 2'b11, "R5", "16-bit write lanes", wr_oe, 3);
        chk(!setup_bad, "R7", "write setup clock", setup_bad, 0);
        chk(!hold_bad, "R7", "write hold clock", hold_bad, 0);
        chk(n_rv == 0, "R6", "no valid on write", n_rv, 0);
    endtask

    task automatic t_read_narrow_after_poke();
        do_access(24'h123401, 1'b0, 1'b0, 16'h0, 5'd0, 16'hA55A, 1'b0);
        chk(n_ale == 0, "R9", "busy-time request ignored (no relatch)", n_ale, 0);
        chk(n_rd == 1, "R4", "duration 0 gives 1 clock", n_rd, 1);
        chk(rd_oe == 2'b10, "R5", "8-bit read upper lanes only", rd_oe, 2);
        chk(rd_bus[15:8] == 8'h01, "R5", "8-bit address byte on upper lanes", rd_bus[15:8], 8'h01);
        chk(rv_data == 16'h005A, "R6", "8-bit read zero extended", rv_data, 16'h005A);
        chk(n_turn == 1 && !turn_bad, "R8", "turnaround after 8-bit read", n_turn, 1);
    endtask

    task automatic t_write_narrow_long();
        do_access(24'h778899, 1'b1, 1'b0, 16'h3C4D, 5'd31, 16'h0, 1'b0);
        chk(n_ale == 1, "R1", "latch on new upper address", n_ale, 1);
        chk(ale_bus == 16'h7788, "R2", "new upper address on bus", ale_bus, 16'h7788);
        chk(n_wr == 31, "R4", "longest strobe", n_wr, 31);
        chk(wr_bus == 16'h994D, "R5", "8-bit write lanes", wr_bus, 16'h994D);
        chk(!setup_bad && !hold_bad, "R7", "setup and hold on long write", {setup_bad, hold_bad}, 0);
    endtask

    task automatic t_read_back_to_old_upper();
        do_access(24'h1234FF, 1'b0, 1'b1, 16'h0, 5'd2, 16'h1357, 1'b0);
        chk(n_ale == 1, "R1", "relatch after upper address changed", n_ale, 1);
        chk(n_rd == 2, "R4", "read strobe length 2", n_rd, 2);
        chk(rv_data == 16'h1357, "R6", "read data after relatch", rv_data, 16'h1357);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first_read_wide();
        t_write_hit_wide_poke();
        t_read_narrow_after_poke();
        t_write_narrow_long();
        t_read_back_to_old_upper();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule